// File: doc/BRIEF.md
# Host Bus Ownership Controller with Deadlock Breaking

This block decides who owns a processor's external bus. Normally the processor is bus master. A host takes the bus through a request/grant handshake. A plain request is granted only at a clean boundary: no local external access and no external DMA transfer may be in flight. The grant then stays up for as long as the host keeps requesting.

A host that is itself waiting on the processor can break the deadlock by raising a suspend input together with its request. The processor is then pushed into slave mode at once, even in the middle of an unfinished local access. That access is marked suspended and is resumed, with a one-cycle resume pulse, after the host lowers both inputs. Two exceptions apply to the forced path. An external DMA transfer in progress holds the grant back until the transfer ends. A set bus-lock bit makes the block float its bus drivers without entering slave mode. A parameter decides which of the two exceptions wins when both are present.

All outputs come from registers. A change on the inputs is therefore seen on the outputs one clock edge later. Data movement is handled elsewhere.

Top module: `hba_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `grant`, `bus_float`, `slave_mode`, `acc_suspended` and `resume` are all 0 (the processor is master with its drivers enabled).
- R2: With `host_req`=1 and `host_susp`=0, the grant is withheld while `loc_busy` or `dma_busy` is 1. In the cycle after an edge that samples the request with both busy flags low, `grant`, `slave_mode` and `bus_float` read 1.
- R3: Once granted, `grant` stays 1 while `host_req` is sampled 1. It reads 0 in the cycle after `host_req` is sampled 0 with `host_susp` also 0.
- R4: From master, an edge that samples `host_req`=1 and `host_susp`=1 with `bus_lock`=0 and `dma_busy`=0 gives `grant`=1, `slave_mode`=1 and `bus_float`=1 in the next cycle, whatever the value of `loc_busy`.
- R5: `acc_suspended` becomes 1 on entry to the forced state (slave or floated) when `loc_busy` was 1 at that edge. It stays 1 while either host input is still 1.
- R6: The forced state is left only at an edge that samples both `host_req` and `host_susp` low. In the next cycle `grant`, `bus_float` and `acc_suspended` are 0. `resume` is 1 for exactly that one cycle, and only if an access had been suspended.
- R7: From master, while `host_req` and `host_susp` are 1 and `dma_busy` is 1 (lock clear), `grant` stays 0. Slave mode follows in the cycle after `dma_busy` is sampled 0.
- R8: From master, `host_req`=1 and `host_susp`=1 with `bus_lock`=1 give `bus_float`=1, `slave_mode`=0 and `grant`=0 in the next cycle.
- R9: With `LOCK_OVER_DMA`=1 (default), a set `bus_lock` wins over a running DMA: both host inputs high with lock and DMA both set still float the bus in the next cycle.
- R10: In the floated state, an edge that samples `bus_lock`=0, `dma_busy`=0 and both host inputs 1 moves the block to slave mode (`grant`=1, `slave_mode`=1) in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host bus request |
| host_susp | input | 1 | Host suspend / force-tristate request |
| loc_busy | input | 1 | Local external access started and not yet complete |
| dma_busy | input | 1 | External DMA transfer in progress |
| bus_lock | input | 1 | Bus lock bit |
| grant | output | 1 | Bus granted to host |
| bus_float | output | 1 | Processor's bus drivers tristated |
| slave_mode | output | 1 | Processor acting as bus slave |
| acc_suspended | output | 1 | A local access is held suspended |
| resume | output | 1 | One-cycle pulse: suspended access may restart |

## Verification
The assertions check on every cycle the local transition rules. Slave mode implies a floated, granted bus. A forced request with no exception present gives slave mode one edge later. The DMA and lock exceptions hold back the grant or slave mode. A held request keeps its grant, the suspended flag persists while the host holds either input, and the resume pulse lasts one cycle and follows a release of both inputs. The bench scenarios are needed for the longer sequences. These include a grant that waits out a local access and then drops, a suspended access that outlives a partial release, a DMA wait that ends in slave mode, and a lock that clears while the host still presses. The randomized run compares all five outputs with a bench model of the rules.

// File: rtl/hba_pkg.sv
package hba_pkg;
   typedef enum logic [1:0] {
      ST_OWN   = 2'd0,   // processor is bus master
      ST_HOST  = 2'd1,   // granted through normal handshake
      ST_FORCE = 2'd2,   // forced slave mode (deadlock break)
      ST_FLOAT = 2'd3    // drivers floated under bus lock
   } hba_state_e;

   function automatic logic st_granted(hba_state_e s);
      return (s == ST_HOST) || (s == ST_FORCE);
   endfunction
endpackage

// File: rtl/hba_decide.sv
module hba_decide
   import hba_pkg::*;
#(
   parameter int unsigned LOCK_OVER_DMA = 1
) (
   input  hba_state_e st,
   input  logic       host_req,
   input  logic       host_susp,
   input  logic       loc_busy,
   input  logic       dma_busy,
   input  logic       bus_lock,
   output hba_state_e nxt
);
   logic lock_wins;
   logic dma_wins;
   logic both_hi;
   logic both_lo;

   if (LOCK_OVER_DMA > 1) begin : g_bad_param
      $error("LOCK_OVER_DMA must be 0 or 1");
   end

   if (LOCK_OVER_DMA == 1) begin : g_lock_first
      assign lock_wins = bus_lock;
      assign dma_wins  = dma_busy & ~bus_lock;
   end else begin : g_dma_first
      assign dma_wins  = dma_busy;
      assign lock_wins = bus_lock & ~dma_busy;
   end

   assign both_hi = host_req & host_susp;
   assign both_lo = ~host_req & ~host_susp;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_OWN: begin
            if (both_hi) begin
               if (lock_wins)      nxt = ST_FLOAT;
               else if (dma_wins)  nxt = ST_OWN;
               else                nxt = ST_FORCE;
            end else if (host_req && !loc_busy && !dma_busy) begin
               nxt = ST_HOST;
            end
         end
         ST_HOST:  nxt = host_req ? ST_HOST : ST_OWN;
         ST_FORCE: nxt = both_lo ? ST_OWN : ST_FORCE;
         ST_FLOAT: begin
            if (both_lo)                                nxt = ST_OWN;
            else if (both_hi && !bus_lock && !dma_busy) nxt = ST_FORCE;
         end
         default: nxt = ST_OWN;
      endcase
   end
endmodule

// File: rtl/hba_susp_track.sv
module hba_susp_track
   import hba_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  hba_state_e st,
   input  hba_state_e nxt,
   input  logic       loc_busy,
   output logic       acc_suspended,
   output logic       resume
);
   logic entering;
   logic leaving;

   assign entering = (st == ST_OWN) && ((nxt == ST_FORCE) || (nxt == ST_FLOAT));
   assign leaving  = ((st == ST_FORCE) || (st == ST_FLOAT)) && (nxt == ST_OWN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_suspended <= 1'b0;
         resume        <= 1'b0;
      end else begin
         if (entering)          acc_suspended <= loc_busy;
         else if (nxt == ST_OWN) acc_suspended <= 1'b0;
         resume <= leaving & acc_suspended;
      end
   end
endmodule

// File: rtl/hba_out_reg.sv
module hba_out_reg
   import hba_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  hba_state_e nxt,
   output hba_state_e st,
   output logic       grant,
   output logic       bus_float,
   output logic       slave_mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_OWN;
         grant      <= 1'b0;
         bus_float  <= 1'b0;
         slave_mode <= 1'b0;
      end else begin
         st         <= nxt;
         grant      <= st_granted(nxt);
         bus_float  <= (nxt != ST_OWN);
         slave_mode <= st_granted(nxt);
      end
   end
endmodule

// File: rtl/hba_ctrl.sv
module hba_ctrl
   import hba_pkg::*;
#(
   parameter int unsigned LOCK_OVER_DMA = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic host_req,
   input  logic host_susp,
   input  logic loc_busy,
   input  logic dma_busy,
   input  logic bus_lock,
   output logic grant,
   output logic bus_float,
   output logic slave_mode,
   output logic acc_suspended,
   output logic resume
);
   hba_state_e st;
   hba_state_e nxt;

   hba_decide #(.LOCK_OVER_DMA(LOCK_OVER_DMA)) i_decide (
      .st        (st),
      .host_req  (host_req),
      .host_susp (host_susp),
      .loc_busy  (loc_busy),
      .dma_busy  (dma_busy),
      .bus_lock  (bus_lock),
      .nxt       (nxt)
   );

   hba_out_reg i_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .nxt        (nxt),
      .st         (st),
      .grant      (grant),
      .bus_float  (bus_float),
      .slave_mode (slave_mode)
   );

   hba_susp_track i_susp (
      .clk           (clk),
      .rst_n         (rst_n),
      .st            (st),
      .nxt           (nxt),
      .loc_busy      (loc_busy),
      .acc_suspended (acc_suspended),
      .resume        (resume)
   );
endmodule

// File: rtl/hba_ctrl_chk.sv
module hba_ctrl_chk #(
   parameter int unsigned LOCK_OVER_DMA = 1
) (
   input logic clk,
   input logic rst_n,
   input logic host_req,
   input logic host_susp,
   input logic loc_busy,
   input logic dma_busy,
   input logic bus_lock,
   input logic grant,
   input logic bus_float,
   input logic slave_mode,
   input logic acc_suspended,
   input logic resume
);
   logic lock_sel;
   assign lock_sel = bus_lock && ((LOCK_OVER_DMA == 1) || !dma_busy);

   // R4: slave mode means granted and floated
   assert_slave_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      slave_mode |-> (grant && bus_float));

   // R2
   assert_wait_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_float && host_req && !host_susp && (loc_busy || dma_busy)) |=> !grant);

   // R3
   assert_hold_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && host_req) |=> grant);

   // R4
   assert_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_float && host_req && host_susp && !bus_lock && !dma_busy) |=> (grant && slave_mode));

   // R5
   assert_susp_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_suspended && (host_req || host_susp)) |=> acc_suspended);

   // R6
   assert_resume_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      resume |=> !resume);
   assert_resume_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resume) |-> ($past(acc_suspended) && !$past(host_req) && !$past(host_susp)));

   // R7
   assert_dma_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_float && host_req && host_susp && dma_busy && !lock_sel) |=> !grant);

   // R8
   assert_lock_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_float && host_req && host_susp && lock_sel) |=> (bus_float && !slave_mode && !grant));
endmodule

bind hba_ctrl hba_ctrl_chk #(.LOCK_OVER_DMA(LOCK_OVER_DMA)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_req      (host_req),
   .host_susp     (host_susp),
   .loc_busy      (loc_busy),
   .dma_busy      (dma_busy),
   .bus_lock      (bus_lock),
   .grant         (grant),
   .bus_float     (bus_float),
   .slave_mode    (slave_mode),
   .acc_suspended (acc_suspended),
   .resume        (resume)
);

// File: tb/test_hba_ctrl.sv
module test_hba_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_req = 0, host_susp = 0, loc_busy = 0, dma_busy = 0, bus_lock = 0;
   logic grant, bus_float, slave_mode, acc_suspended, resume;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // bench model: 0 master, 1 host grant, 2 forced slave, 3 floated
   int  m_st = 0;
   bit  m_susp = 0;
   bit  m_res = 0;

   always #2 clk = ~clk;   // 250 MHz

   hba_ctrl i_hba_ctrl (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_susp(host_susp),
      .loc_busy(loc_busy), .dma_busy(dma_busy), .bus_lock(bus_lock),
      .grant(grant), .bus_float(bus_float), .slave_mode(slave_mode),
      .acc_suspended(acc_suspended), .resume(resume)
   );

   function automatic int next_state(int s, bit rq, bit sp, bit lb, bit db, bit lk);
      if (s == 0) begin
         if (rq && sp) begin
            if (lk) return 3;          // lock has priority (default parameter)
            if (db) return 0;
            return 2;
         end
         if (rq && !lb && !db) return 1;
         return 0;
      end
      if (s == 1) return rq ? 1 : 0;
      if (s == 2) return (!rq && !sp) ? 0 : 2;
      if (!rq && !sp) return 0;
      if (rq && sp && !lk && !db) return 2;
      return 3;
   endfunction

   function automatic logic [4:0] exp_out();
      logic g;
      g = (m_st == 1) || (m_st == 2);
      return {g, (m_st != 0), g, m_susp, m_res};
   endfunction

   task automatic check(string tag);
      logic [4:0] act;
      logic [4:0] exp;
      act = {grant, bus_float, slave_mode, acc_suspended, resume};
      exp = exp_out();
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {grant,float,slave,susp,resume} actual %b expected %b", tag, act, exp);
      end
   endtask

   // advance one clock edge with the current inputs, then check
   task automatic cyc(string tag);
      int n;
      n = next_state(m_st, host_req, host_susp, loc_busy, dma_busy, bus_lock);
      @(posedge clk);
      #1;
      m_res = (m_st >= 2) && (n == 0) && m_susp;
      if (m_st == 0 && n >= 2) m_susp = loc_busy;
      else if (n == 0)         m_susp = 0;
      m_st = n;
      check(tag);
   endtask

   task automatic set_in(bit rq, bit sp, bit lb, bit db, bit lk);
      host_req = rq; host_susp = sp; loc_busy = lb; dma_busy = db; bus_lock = lk;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      check("R1 in reset");
      rst_n = 1'b1;
      cyc("R1 after reset");

      // R2 / R3: normal handshake waits on local access
      set_in(1, 0, 1, 0, 0);
      cyc("R2 wait loc_busy");
      cyc("R2 wait loc_busy 2");
      set_in(1, 0, 0, 1, 0);
      cyc("R2 wait dma_busy");
      set_in(1, 0, 0, 0, 0);
      cyc("R2 granted");
      set_in(1, 0, 1, 0, 0);
      cyc("R3 held");
      set_in(0, 0, 0, 0, 0);
      cyc("R3 released");

      // R4 / R5 / R6: forced slave mid-access
      set_in(1, 1, 1, 0, 0);
      cyc("R4 forced slave with R5 suspend");
      set_in(0, 1, 0, 0, 0);
      cyc("R5 partial release keeps suspend");
      set_in(0, 0, 0, 0, 0);
      cyc("R6 resume pulse");
      cyc("R6 pulse ends");

      // R7: DMA holds forced grant
      set_in(1, 1, 0, 1, 0);
      cyc("R7 dma withholds");
      cyc("R7 dma withholds 2");
      set_in(1, 1, 0, 0, 0);
      cyc("R7 granted after dma");
      set_in(0, 0, 0, 0, 0);
      cyc("R6 no resume without suspend");

      // R8 / R9 / R10: lock
      set_in(1, 1, 1, 0, 1);
      cyc("R8 lock floats without slave");
      set_in(0, 0, 0, 0, 0);
      cyc("R6 resume after float");
      cyc("R6 pulse ends after float");
      set_in(1, 1, 0, 1, 1);
      cyc("R9 lock beats dma");
      set_in(1, 1, 0, 0, 0);
      cyc("R10 lock cleared -> slave");
      set_in(0, 0, 0, 0, 0);
      cyc("R10 release");

      // randomized traffic against the model
      for (int i = 0; i < 4000; i++) begin
         set_in(($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 2) == 0,
                ($urandom % 4) == 0, ($urandom % 6) == 0);
         if (($urandom % 5) == 0) set_in(0, 0, host_req, 0, 0);
         cyc("MODEL random");
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule